// File: doc/BRIEF.md
# Parity-Checked Windowed Register File

This block is the general-register store of a pipelined integer core. It has one write port and two read ports, all usable in every cycle. Logical register numbers are turned into physical entries through a current-window pointer. A small set of global registers is shared by every window. Each window also has private locals and an output group. A window's input group is the output group of the next window up, so a caller and a callee exchange arguments without copying them.

Every stored word carries one even-parity bit, computed from the write data in the cycle it is written. Reads are registered. A read port flags a parity mismatch only when its operand-used qualifier was high for that read. A register that was never written, or that was corrupted but is not consumed, therefore raises no error. When either port flags, the block offers the register-file parity trap code to the core's trap logic. A fault-injection input flips one stored bit so that the detection paths can be exercised.

Top module: `winrf_par_top`

## Requirements
- R1: While rst_ni is low, and after it until the first read is captured, both read data outputs, both parity flags, err_o and trap_type_o are zero.
- R2: A word written through the write port is returned unchanged by either read port one clock after the read address is presented.
- R3: Logical numbers 0-7 address the 8 globals (physical 0-7) in every window. 8-15 (outputs) map to physical 8+16*cwp+(n-8). 16-23 (locals) map to physical 8+16*cwp+(n-8). 24-31 (inputs) map to physical 8+16*((cwp+1) mod 8)+(n-24), so the inputs of window w are the outputs of window w+1.
- R4: Each entry stores data in bits 31:0 and even parity in bit 32. If one stored bit is flipped and that entry is read with its port's use qualifier high, that port's parity flag is 1 one clock later.
- R5: A read with the use qualifier low never raises that port's parity flag, even on a corrupted entry, and still presents the stored (corrupted) data.
- R6: err_o is the OR of the two port flags. trap_type_o is 0x64 when err_o is 1 and 0x00 otherwise.
- R7: When a write and a read target the same physical entry in one cycle, the read returns the newly written data and its fresh parity.
- R8: Rewriting a corrupted entry regenerates its parity, so a later used read of it raises no flag.
- R9: Fault injection (inj_en_i) flips bit inj_bit_i (0-31 data, 32 parity) of physical entry inj_idx_i at the clock edge. A write to the same entry in that cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cwp_i | input | 3 | Current window pointer |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Logical write register |
| wdata_i | input | 32 | Write data |
| raddr_a_i | input | 5 | Logical read register, port A |
| use_a_i | input | 1 | Port A operand is consumed |
| raddr_b_i | input | 5 | Logical read register, port B |
| use_b_i | input | 1 | Port B operand is consumed |
| inj_en_i | input | 1 | Fault-injection strobe |
| inj_idx_i | input | 8 | Physical entry to corrupt |
| inj_bit_i | input | 6 | Bit to flip (32 = parity) |
| rdata_a_o | output | 32 | Port A read data |
| rdata_b_o | output | 32 | Port B read data |
| perr_a_o | output | 1 | Port A parity error |
| perr_b_o | output | 1 | Port B parity error |
| err_o | output | 1 | Any port parity error |
| trap_type_o | output | 8 | Trap code for the core |

## Verification
A wrong window map shows up as a wrong word on a read port. The ins-to-outs alias between adjacent windows, and the globals seen from every window, expose it on the first read that crosses the fault. Wrong parity generation or a broken use gate shows as a spurious or missing flag and trap code one clock after the affected read. A broken bypass returns stale data in the cycle right after a write-and-read collision. The reference model predicts every output on every clock, so each of these faults appears within one cycle of the read that exposes it.

// File: rtl/winrf_pkg.sv
package winrf_pkg;
  localparam logic [7:0] RF_PAR_TRAP = 8'h64;

  function automatic logic even_par(input logic [63:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/winrf_map.sv
// Logical register number + window pointer -> physical entry.
module winrf_map #(
  parameter int N_GLOBAL  = 8,
  parameter int N_WIN     = 8,
  parameter int WIN_SLOTS = 16,
  parameter int LA_W      = 5,
  parameter int PA_W      = 8,
  parameter int CWP_W     = 3
) (
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [LA_W-1:0]  laddr_i,
  output logic [PA_W-1:0]  phys_o
);
  localparam int HALF = WIN_SLOTS / 2;

  always_comb begin
    int l, w, p;
    l = int'(laddr_i);
    w = int'(cwp_i);
    if (l < N_GLOBAL)
      p = l;
    else if (l < N_GLOBAL + 2*HALF)
      p = N_GLOBAL + w*WIN_SLOTS + (l - N_GLOBAL);
    else
      p = N_GLOBAL + ((w + 1) % N_WIN)*WIN_SLOTS + (l - N_GLOBAL - 2*HALF);
    phys_o = PA_W'(p);
  end
endmodule

// File: rtl/winrf_store.sv
// Storage array: data in [DW-1:0], parity in [DW]. Not reset: check bits undefined at power-up.
module winrf_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 136,
  parameter int PA_W  = 8,
  parameter int BIT_W = 6,
  parameter int N_RD  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PA_W-1:0]   widx_i,
  input  logic [DW:0]       wword_i,
  input  logic              inj_en_i,
  input  logic [PA_W-1:0]   inj_idx_i,
  input  logic [BIT_W-1:0]  inj_bit_i,
  input  logic [PA_W-1:0]   rd_idx_i  [N_RD],
  output logic [DW:0]       rd_word_o [N_RD]
);
  logic [DW:0] mem [DEPTH];

  logic inj_ok;
  assign inj_ok = inj_en_i && (inj_idx_i < PA_W'(DEPTH)) && (inj_bit_i <= BIT_W'(DW));

  always_ff @(posedge clk_i) begin
    if (inj_ok) mem[inj_idx_i][inj_bit_i] <= ~mem[inj_idx_i][inj_bit_i];
    if (we_i)   mem[widx_i] <= wword_i;   // write wins over injection
  end

  for (genvar g = 0; g < N_RD; g++) begin : g_rd
    assign rd_word_o[g] = mem[rd_idx_i[g]];
  end

  // R8: a plain write leaves an entry with even parity.
  assert_par_fresh_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && !($past(inj_en_i) && $past(inj_idx_i) == $past(widx_i)))
      |-> (^mem[$past(widx_i)]) == 1'b0);
endmodule

// File: rtl/winrf_rdport.sv
// Registered read port with write bypass and use-qualified parity check.
module winrf_rdport #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          use_i,
  input  logic [DW:0]   word_i,
  input  logic          byp_i,
  input  logic [DW:0]   byp_word_i,
  output logic [DW-1:0] rdata_o,
  output logic          perr_o
);
  logic [DW:0] word_q;
  logic        use_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      use_q  <= 1'b0;
    end else begin
      word_q <= byp_i ? byp_word_i : word_i;
      use_q  <= use_i;
    end
  end

  assign rdata_o = word_q[DW-1:0];
  assign perr_o  = use_q & (^word_q);

  assert_bypass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byp_i |=> word_q == $past(byp_word_i));
endmodule

// File: rtl/winrf_par_top.sv
module winrf_par_top #(
  parameter int DATA_W    = 32,
  parameter int N_GLOBAL  = 8,
  parameter int N_WIN     = 8,
  parameter int WIN_SLOTS = 16,
  localparam int HALF     = WIN_SLOTS / 2,
  localparam int DEPTH    = N_GLOBAL + N_WIN * WIN_SLOTS,
  localparam int LA_W     = $clog2(N_GLOBAL + 3 * HALF),
  localparam int PA_W     = $clog2(DEPTH),
  localparam int CWP_W    = $clog2(N_WIN),
  localparam int BIT_W    = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CWP_W-1:0]  cwp_i,
  input  logic              we_i,
  input  logic [LA_W-1:0]   waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LA_W-1:0]   raddr_a_i,
  input  logic              use_a_i,
  input  logic [LA_W-1:0]   raddr_b_i,
  input  logic              use_b_i,
  input  logic              inj_en_i,
  input  logic [PA_W-1:0]   inj_idx_i,
  input  logic [BIT_W-1:0]  inj_bit_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic [DATA_W-1:0] rdata_b_o,
  output logic              perr_a_o,
  output logic              perr_b_o,
  output logic              err_o,
  output logic [7:0]        trap_type_o
);
  import winrf_pkg::*;
  localparam int N_RD = 2;

  logic [LA_W-1:0]   rd_laddr [N_RD];
  logic              rd_use   [N_RD];
  logic [PA_W-1:0]   rd_phys  [N_RD];
  logic [DATA_W:0]   rd_word  [N_RD];
  logic [DATA_W-1:0] rd_data  [N_RD];
  logic              rd_perr  [N_RD];
  logic [PA_W-1:0]   w_phys;
  logic [DATA_W:0]   w_word;

  assign rd_laddr[0] = raddr_a_i;
  assign rd_laddr[1] = raddr_b_i;
  assign rd_use[0]   = use_a_i;
  assign rd_use[1]   = use_b_i;
  assign w_word      = {even_par(64'(wdata_i)), wdata_i};

  winrf_map #(.N_GLOBAL(N_GLOBAL), .N_WIN(N_WIN), .WIN_SLOTS(WIN_SLOTS),
              .LA_W(LA_W), .PA_W(PA_W), .CWP_W(CWP_W)) u_wmap (
    .cwp_i(cwp_i), .laddr_i(waddr_i), .phys_o(w_phys));

  winrf_store #(.DW(DATA_W), .DEPTH(DEPTH), .PA_W(PA_W), .BIT_W(BIT_W), .N_RD(N_RD)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .widx_i(w_phys), .wword_i(w_word),
    .inj_en_i(inj_en_i), .inj_idx_i(inj_idx_i), .inj_bit_i(inj_bit_i),
    .rd_idx_i(rd_phys), .rd_word_o(rd_word));

  for (genvar g = 0; g < N_RD; g++) begin : g_port
    winrf_map #(.N_GLOBAL(N_GLOBAL), .N_WIN(N_WIN), .WIN_SLOTS(WIN_SLOTS),
                .LA_W(LA_W), .PA_W(PA_W), .CWP_W(CWP_W)) u_rmap (
      .cwp_i(cwp_i), .laddr_i(rd_laddr[g]), .phys_o(rd_phys[g]));

    winrf_rdport #(.DW(DATA_W)) u_rd (
      .clk_i(clk_i), .rst_ni(rst_ni), .use_i(rd_use[g]), .word_i(rd_word[g]),
      .byp_i(we_i && (w_phys == rd_phys[g])), .byp_word_i(w_word),
      .rdata_o(rd_data[g]), .perr_o(rd_perr[g]));
  end

  assign rdata_a_o   = rd_data[0];
  assign rdata_b_o   = rd_data[1];
  assign perr_a_o    = rd_perr[0];
  assign perr_b_o    = rd_perr[1];
  assign err_o       = perr_a_o | perr_b_o;
  assign trap_type_o = err_o ? RF_PAR_TRAP : 8'h00;

  assert_flag_a_needs_use_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_a_o |-> $past(use_a_i));
  assert_flag_b_needs_use_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_b_o |-> $past(use_b_i));
  assert_trap_with_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_type_o != 8'h00) == err_o);
  assert_err_needs_use_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(use_a_i || use_b_i));
endmodule

// File: tb/tb_winrf_par_top.sv
`timescale 1ns/1ps
module tb_winrf_par_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cwp = '0;
  logic        we = 1'b0;
  logic [4:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [4:0]  ra = '0, rb = '0;
  logic        ua = 1'b0, ub = 1'b0;
  logic        inj = 1'b0;
  logic [7:0]  inj_idx = '0;
  logic [5:0]  inj_bit = '0;
  logic [31:0] rda, rdb;
  logic        pea, peb, err;
  logic [7:0]  trap;

  always #4 clk = ~clk;  // 125 MHz

  winrf_par_top dut (
    .clk_i(clk), .rst_ni(rst_n), .cwp_i(cwp), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_a_i(ra), .use_a_i(ua), .raddr_b_i(rb), .use_b_i(ub),
    .inj_en_i(inj), .inj_idx_i(inj_idx), .inj_bit_i(inj_bit),
    .rdata_a_o(rda), .rdata_b_o(rdb), .perr_a_o(pea), .perr_b_o(peb),
    .err_o(err), .trap_type_o(trap));

  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference
  logic [32:0] m   [136];
  bit          kn  [136];
  logic [32:0] ex_w [2];
  bit          ex_k [2];
  bit          ex_u [2];

  function automatic int phys(int c, int r);
    if (r < 8)  return r;
    if (r < 24) return 8 + 16*c + (r - 8);
    return 8 + 16*((c + 1) % 8) + (r - 24);
  endfunction

  function automatic logic [31:0] pat(int c, int r);
    return 32'h9E3779B9 * (c*32 + r + 1) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  initial for (int i = 0; i < 136; i++) kn[i] = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin ex_w[p] = '0; ex_k[p] = 1; ex_u[p] = 0; end
    end else begin
      int pw, pr[2];
      pw = phys(cwp, waddr);
      pr[0] = phys(cwp, ra);
      pr[1] = phys(cwp, rb);
      ex_u[0] = ua; ex_u[1] = ub;
      for (int p = 0; p < 2; p++) begin
        if (we && pw == pr[p]) begin ex_w[p] = {^wdata, wdata}; ex_k[p] = 1; end
        else begin ex_w[p] = m[pr[p]]; ex_k[p] = kn[pr[p]]; end
      end
      if (inj && inj_idx < 136 && inj_bit <= 32) m[inj_idx][inj_bit] = ~m[inj_idx][inj_bit];
      if (we) begin m[pw] = {^wdata, wdata}; kn[pw] = 1; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit pe[2];
      for (int p = 0; p < 2; p++) pe[p] = ex_u[p] & (^ex_w[p]);
      if (ex_k[0]) begin chk("rdata_a", rda, ex_w[0][31:0]); chk("perr_a", 32'(pea), 32'(pe[0])); end
      if (ex_k[1]) begin chk("rdata_b", rdb, ex_w[1][31:0]); chk("perr_b", 32'(peb), 32'(pe[1])); end
      if ((ex_k[0] || !ex_u[0]) && (ex_k[1] || !ex_u[1])) begin
        chk("err", 32'(err), 32'(pe[0] | pe[1]));
        chk("trap", 32'(trap), (pe[0] | pe[1]) ? 32'h64 : 32'h0);
      end
    end
  end

  task automatic cyc(int c, bit w, int wa, logic [31:0] wd, int a, bit a_u, int b, bit b_u,
                     bit fi = 0, int fidx = 0, int fbit = 0);
    cwp = 3'(c); we = w; waddr = 5'(wa); wdata = wd;
    ra = 5'(a); ua = a_u; rb = 5'(b); ub = b_u;
    inj = fi; inj_idx = 8'(fidx); inj_bit = 6'(fbit);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("rdata_a", rda, 0); chk("rdata_b", rdb, 0);
    chk("perr_a", 32'(pea), 0); chk("perr_b", 32'(peb), 0);
    chk("err", 32'(err), 0); chk("trap", 32'(trap), 0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);

    // R2: fill every physical entry (globals, then outs+locals per window)
    tag = "R2";
    for (int r = 0; r < 8; r++) cyc(0, 1, r, pat(0, r), 0, 0, 0, 0);
    for (int c = 0; c < 8; c++)
      for (int r = 8; r < 24; r++) cyc(c, 1, r, pat(c, r), 0, 0, 0, 0);
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 24; r++) cyc(c, 0, 0, 0, r, 1, 23 - r, 1);

    // R3: ins of window c alias outs of window c+1; globals shared
    tag = "R3";
    for (int c = 0; c < 8; c++)
      for (int r = 24; r < 32; r++) cyc(c, 0, 0, 0, r, 1, r - 16, 1);
    cyc(3, 1, 26, 32'hC0FFEE03, 0, 0, 0, 0);   // write ins of window 3
    cyc(4, 0, 0, 0, 10, 1, 26, 1);              // read outs of window 4, ins of 4
    cyc(5, 1, 5, 32'h0BADF00D, 0, 0, 0, 0);     // global from window 5
    cyc(2, 0, 0, 0, 5, 1, 16, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);

    // R9 + R4: flip data bit 7 of window 2 local 17 (phys 49); parity bit of global 3
    tag = "R9";
    cyc(2, 0, 0, 0, 0, 0, 0, 0, 1, 49, 7);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 3, 32);
    tag = "R4";
    cyc(2, 0, 0, 0, 17, 1, 0, 0);
    cyc(2, 0, 0, 0, 0, 0, 3, 1);
    cyc(2, 0, 0, 0, 1, 1, 2, 1);

    // R5: corrupted entries read without use
    tag = "R5";
    cyc(2, 0, 0, 0, 17, 0, 3, 0);
    cyc(6, 0, 0, 0, 3, 0, 12, 1);

    // R6: both ports flag; one port flags
    tag = "R6";
    cyc(2, 0, 0, 0, 17, 1, 3, 1);
    cyc(2, 0, 0, 0, 8, 1, 3, 1);
    cyc(2, 0, 0, 0, 8, 1, 9, 1);

    // R7: same-cycle write/read, direct and through the window alias
    tag = "R7";
    cyc(1, 1, 20, 32'h13572468, 20, 1, 20, 0);
    cyc(0, 1, 24, 32'hFEDCBA98, 7, 1, 24, 1);
    cyc(1, 1, 8, 32'h2468ACE1, 8, 1, 0, 0);
    cyc(0, 0, 0, 0, 24, 1, 0, 0);

    // R8: rewriting corrupted entries clears the flag; write beats same-cycle injection
    tag = "R8";
    cyc(2, 1, 17, 32'hA1B2C3D4, 0, 0, 0, 0);
    cyc(2, 1, 3, 32'h0F0F0F0F, 17, 1, 0, 0);
    cyc(2, 0, 0, 0, 17, 1, 3, 1);
    cyc(4, 1, 16, 32'h11112222, 0, 0, 0, 0, 1, 8 + 64 + 8, 0);
    cyc(4, 0, 0, 0, 16, 1, 16, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end
endmodule